// File: doc/BRIEF.md
# Pixel Row Cluster Builder

This block sits in a pixel readout chain after the stage that orders hits by column. Every hit word holds a marker flag, a 7-bit row, a 5-bit column, an 8-bit crossing stamp and a 3-bit pulse height. A sensor chip has 128 rows (0 to 127) and 22 columns (0 to 21). Within one column the rows arrive in ascending order. The block joins hits that share a column and a crossing stamp and whose rows follow each other without a gap. Each such run becomes one descriptor that carries the column, the first row, the last row, the crossing stamp and a saturating charge sum. A later stage uses these descriptors to merge clusters across columns.

A cluster stays open until a hit arrives that cannot extend it. The block then emits the cluster and opens a new one from that hit. A hit with the marker flag set carries no charge. It closes any open cluster and then travels to the output unchanged, tagged as a marker.

Both sides use valid/ready. A word is transferred on a rising clock edge when valid and ready are both high. Once the output shows valid, its data holds until the consumer takes it. The input ready may depend on the input word itself. A hit that only extends the open cluster is always taken, even while the output is stalled. A hit that has to emit something is taken only when the output slot is free or is being drained in the same cycle.

Top module: `row_cluster_builder`

## Requirements
- R1: While reset is low and in the first cycle after it, `o_valid` is 0 and no cluster is open, so the first input word produces no flush.
- R2: A non-marker hit extends the open cluster when its column and crossing equal the cluster's and its row equals the cluster's last row plus one. The descriptor then reports the column, the first and last rows, the crossing and the charge sum of all member hits.
- R3: A non-marker hit in a different column closes the open cluster. The closed cluster appears on the output (`o_valid`=1) in the cycle that follows the edge where the closing hit was accepted.
- R4: A row that is not exactly the last row plus one closes the cluster. This includes a repeated row, a skipped row and row 0 after row 127, so rows never wrap around.
- R5: A hit with a different crossing stamp closes the cluster, even when its column and row would be adjacent.
- R6: The charge field is 6 bits wide and saturates at 63. A cluster whose pulse heights add up to more than 63 reports 63.
- R7: A marker word (`in_sync`=1) that arrives while a cluster is open first causes that cluster to be emitted. The marker is then emitted with `o_marker`=1, its row in both row fields, its column and crossing, and its 3-bit pulse height zero-extended into the charge field.
- R8: While `o_valid`=1 and `o_ready`=0, the output data holds steady. A hit that needs the output slot is refused (`in_ready`=0) during that time, while a hit that extends the open cluster is still accepted. No descriptor is lost or duplicated.
- R9: A marker that arrives with no cluster open is accepted at once when the output slot is free, and it appears on the output in the next cycle.
- R10: A cluster made of a single hit reports the same row as its first and last row and that hit's pulse height as its charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts the input word |
| in_sync | input | 1 | Marker flag of the input word |
| in_row | input | 7 | Row number |
| in_col | input | 5 | Column number |
| in_xing | input | 8 | Crossing stamp |
| in_adc | input | 3 | Pulse height |
| o_valid | output | 1 | Descriptor valid |
| o_ready | input | 1 | Consumer takes the descriptor |
| o_marker | output | 1 | Descriptor is a passed-through marker |
| o_col | output | 5 | Column |
| o_row_first | output | 7 | First row of the cluster |
| o_row_last | output | 7 | Last row of the cluster |
| o_xing | output | 8 | Crossing stamp |
| o_charge | output | 6 | Saturating charge sum |

## Verification
A closed cluster or a marker with nothing open is due one cycle after the edge that accepts the closing word. A marker that arrives while a cluster is open takes at least two output cycles: first the flushed cluster, then the marker. The bench drives inputs at the falling edge and reads `in_ready` and the outputs 1 ns before the next rising edge. It scores a descriptor only in a cycle where `o_valid` and `o_ready` are both high, comparing it against an ordered queue of expected descriptors. The stall test checks the one-cycle latency directly, then checks over several cycles that the output holds and that `in_ready` stays low.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  localparam int ROW_W   = 7;
  localparam int COL_W   = 5;
  localparam int XING_W  = 8;
  localparam int ADC_W   = 3;
  localparam int CHG_W   = 6;
  localparam int CHG_MAX = (1 << CHG_W) - 1;

  typedef struct packed {
    logic              sync;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [XING_W-1:0] xing;
    logic [ADC_W-1:0]  adc;
  } hit_t;

  typedef struct packed {
    logic              marker;
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  first;
    logic [ROW_W-1:0]  last;
    logic [XING_W-1:0] xing;
    logic [CHG_W-1:0]  charge;
  } desc_t;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_OPEN,
    ACT_EXTEND,
    ACT_CLOSE_OPEN,
    ACT_FLUSH,
    ACT_MARK
  } act_e;

  function automatic logic [CHG_W-1:0] sat_add(input logic [CHG_W-1:0] acc,
                                               input logic [ADC_W-1:0] adc);
    logic [CHG_W:0] sum;
    sum = {1'b0, acc} + {{(CHG_W + 1 - ADC_W){1'b0}}, adc};
    if (sum > (CHG_W + 1)'(CHG_MAX)) return CHG_W'(CHG_MAX);
    return sum[CHG_W-1:0];
  endfunction
endpackage

// File: rtl/rcb_merge_ctl.sv
module rcb_merge_ctl
  import rcb_pkg::*;
(
  input  logic  in_valid,
  input  hit_t  hit,
  input  logic  open,
  input  desc_t cur,
  input  logic  slot_free,
  output act_e  act,
  output logic  in_ready
);
  localparam int NXT_W = ROW_W + 1;

  logic [NXT_W-1:0] next_row;
  logic             adjacent;

  assign next_row = {1'b0, cur.last} + NXT_W'(1);
  assign adjacent = open && (hit.col == cur.col) && (hit.xing == cur.xing) &&
                    ({1'b0, hit.row} == next_row);

  always_comb begin
    act      = ACT_IDLE;
    in_ready = 1'b1;
    if (in_valid) begin
      if (hit.sync) begin
        if (open) begin
          in_ready = 1'b0;
          if (slot_free) act = ACT_FLUSH;
        end else if (slot_free) begin
          act = ACT_MARK;
        end else begin
          in_ready = 1'b0;
        end
      end else if (adjacent) begin
        act = ACT_EXTEND;
      end else if (!open) begin
        act = ACT_OPEN;
      end else if (slot_free) begin
        act = ACT_CLOSE_OPEN;
      end else begin
        in_ready = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rcb_cluster_reg.sv
module rcb_cluster_reg
  import rcb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  act_e  act,
  input  hit_t  hit,
  output logic  open,
  output desc_t cur
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open <= 1'b0;
      cur  <= '0;
    end else begin
      unique case (act)
        ACT_OPEN, ACT_CLOSE_OPEN: begin
          open       <= 1'b1;
          cur.marker <= 1'b0;
          cur.col    <= hit.col;
          cur.first  <= hit.row;
          cur.last   <= hit.row;
          cur.xing   <= hit.xing;
          cur.charge <= {{(CHG_W - ADC_W){1'b0}}, hit.adc};
        end
        ACT_EXTEND: begin
          cur.last   <= hit.row;
          cur.charge <= sat_add(cur.charge, hit.adc);
        end
        ACT_FLUSH: open <= 1'b0;
        default: ;
      endcase
    end
  end

  // R2: an extension advances the last row by exactly one
  a_r2_extend_step: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_EXTEND) |=> (cur.last == $past(cur.last) + 7'd1));

  // R6: the charge never decreases while a cluster grows
  a_r6_charge_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_EXTEND) |=> (cur.charge >= $past(cur.charge)));

  // R7: a flush leaves no cluster open
  a_r7_flush_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_FLUSH) |=> !open);
endmodule

// File: rtl/rcb_out_stage.sv
module rcb_out_stage
  import rcb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  desc_t load_data,
  input  logic  o_ready,
  output logic  o_valid,
  output desc_t o_data,
  output logic  slot_free
);
  assign slot_free = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
    end else if (load) begin
      o_valid <= 1'b1;
      o_data  <= load_data;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end

  // R8: a stalled descriptor holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));

  // R8: the control never overwrites an untaken descriptor
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!o_valid || o_ready));

  // R2: a cluster's rows are ordered
  a_r2_row_order: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_data.marker) |-> (o_data.last >= o_data.first));
endmodule

// File: rtl/row_cluster_builder.sv
module row_cluster_builder
  import rcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sync,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic [XING_W-1:0] in_xing,
  input  logic [ADC_W-1:0]  in_adc,
  output logic              o_valid,
  input  logic              o_ready,
  output logic              o_marker,
  output logic [COL_W-1:0]  o_col,
  output logic [ROW_W-1:0]  o_row_first,
  output logic [ROW_W-1:0]  o_row_last,
  output logic [XING_W-1:0] o_xing,
  output logic [CHG_W-1:0]  o_charge
);
  hit_t  hit;
  act_e  act;
  logic  open;
  desc_t cur;
  logic  slot_free;
  logic  load;
  desc_t load_data;
  desc_t mark_desc;
  desc_t o_data;

  assign hit = '{sync: in_sync, row: in_row, col: in_col, xing: in_xing, adc: in_adc};

  rcb_merge_ctl u_ctl (
    .in_valid (in_valid),
    .hit      (hit),
    .open     (open),
    .cur      (cur),
    .slot_free(slot_free),
    .act      (act),
    .in_ready (in_ready)
  );

  rcb_cluster_reg u_clu (
    .clk  (clk),
    .rst_n(rst_n),
    .act  (act),
    .hit  (hit),
    .open (open),
    .cur  (cur)
  );

  assign mark_desc = '{marker: 1'b1, col: hit.col, first: hit.row, last: hit.row,
                       xing: hit.xing, charge: {{(CHG_W - ADC_W){1'b0}}, hit.adc}};
  assign load      = (act == ACT_FLUSH) || (act == ACT_CLOSE_OPEN) || (act == ACT_MARK);
  assign load_data = (act == ACT_MARK) ? mark_desc : cur;

  rcb_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_data(load_data),
    .o_ready  (o_ready),
    .o_valid  (o_valid),
    .o_data   (o_data),
    .slot_free(slot_free)
  );

  assign o_marker    = o_data.marker;
  assign o_col       = o_data.col;
  assign o_row_first = o_data.first;
  assign o_row_last  = o_data.last;
  assign o_xing      = o_data.xing;
  assign o_charge    = o_data.charge;

  // R9: an accepted marker is on the output in the next cycle
  a_r9_marker_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sync) |=> (o_valid && o_marker));

  // R7: a marker is never accepted while a cluster is open
  a_r7_marker_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sync) |-> !open);
endmodule

// File: tb/row_cluster_builder_tb.sv
`timescale 1ns/1ps
module row_cluster_builder_tb;
  import rcb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_sync = 1'b0;
  logic [ROW_W-1:0] in_row = '0;
  logic [COL_W-1:0] in_col = '0;
  logic [XING_W-1:0] in_xing = '0;
  logic [ADC_W-1:0] in_adc = '0;
  logic o_valid;
  logic o_ready = 1'b1;
  logic o_marker;
  logic [COL_W-1:0] o_col;
  logic [ROW_W-1:0] o_row_first, o_row_last;
  logic [XING_W-1:0] o_xing;
  logic [CHG_W-1:0] o_charge;

  always #2 clk = ~clk;

  row_cluster_builder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sync(in_sync), .in_row(in_row), .in_col(in_col), .in_xing(in_xing),
    .in_adc(in_adc), .o_valid(o_valid), .o_ready(o_ready), .o_marker(o_marker),
    .o_col(o_col), .o_row_first(o_row_first), .o_row_last(o_row_last),
    .o_xing(o_xing), .o_charge(o_charge)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  desc_t eq[$];
  int    etag[$];

  // stimulus: {sync, row, col, xing, adc}
  localparam int NS = 12;
  localparam hit_t STIM [NS] = '{
    '{1'b0, 7'd10,  5'd3, 8'd5, 3'd2},   // R2 opens
    '{1'b0, 7'd11,  5'd3, 8'd5, 3'd4},   // R2 extends
    '{1'b0, 7'd12,  5'd3, 8'd5, 3'd1},   // R2 extends
    '{1'b0, 7'd12,  5'd4, 8'd5, 3'd3},   // R3 column change
    '{1'b0, 7'd14,  5'd4, 8'd5, 3'd6},   // R4 row gap, R10 single hit
    '{1'b0, 7'd15,  5'd4, 8'd6, 3'd2},   // R5 crossing change
    '{1'b1, 7'd99,  5'd7, 8'd9, 3'd5},   // R7 marker flushes
    '{1'b1, 7'd1,   5'd2, 8'd3, 3'd0},   // R9 marker with nothing open
    '{1'b0, 7'd127, 5'd0, 8'd1, 3'd7},
    '{1'b0, 7'd0,   5'd0, 8'd1, 3'd7},   // R4 no wrap after 127
    '{1'b0, 7'd0,   5'd0, 8'd1, 3'd1},   // R4 repeated row
    '{1'b1, 7'd0,   5'd0, 8'd0, 3'd0}    // R7 flush then marker
  };
  // expected: {marker, col, first, last, xing, charge}
  localparam int NE = 10;
  localparam desc_t EXP [NE] = '{
    '{1'b0, 5'd3, 7'd10,  7'd12,  8'd5, 6'd7},  // R2
    '{1'b0, 5'd4, 7'd12,  7'd12,  8'd5, 6'd3},  // R3 R10
    '{1'b0, 5'd4, 7'd14,  7'd14,  8'd5, 6'd6},  // R4
    '{1'b0, 5'd4, 7'd15,  7'd15,  8'd6, 6'd2},  // R5 R7
    '{1'b1, 5'd7, 7'd99,  7'd99,  8'd9, 6'd5},  // R7
    '{1'b1, 5'd2, 7'd1,   7'd1,   8'd3, 6'd0},  // R9
    '{1'b0, 5'd0, 7'd127, 7'd127, 8'd1, 6'd7},  // R4
    '{1'b0, 5'd0, 7'd0,   7'd0,   8'd1, 6'd7},  // R4
    '{1'b0, 5'd0, 7'd0,   7'd0,   8'd1, 6'd1},  // R7
    '{1'b1, 5'd0, 7'd0,   7'd0,   8'd0, 6'd0}   // R7
  };
  localparam int ETAG [NE] = '{2, 3, 4, 5, 7, 9, 4, 4, 7, 7};

  task automatic check(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic push(input desc_t d, input int tag);
    eq.push_back(d);
    etag.push_back(tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  // output monitor: a transfer happens on the coming edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && o_valid && o_ready) begin
        desc_t got;
        got = '{marker: o_marker, col: o_col, first: o_row_first, last: o_row_last,
                xing: o_xing, charge: o_charge};
        n_checks++;
        if (eq.size() == 0) begin
          n_fails++;
          $display("FAIL R8 unexpected descriptor: actual %h expected none", got);
        end else begin
          if (got !== eq[0]) begin
            n_fails++;
            $display("FAIL R%0d descriptor: actual %h expected %h", etag[0], got, eq[0]);
          end
          void'(eq.pop_front());
          void'(etag.pop_front());
        end
      end
    end
  end

  task automatic drive(input hit_t h);
    in_valid = 1'b1;
    in_sync  = h.sync;
    in_row   = h.row;
    in_col   = h.col;
    in_xing  = h.xing;
    in_adc   = h.adc;
  endtask

  task automatic send(input hit_t h);
    @(negedge clk);
    drive(h);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain(input int max_cycles);
    for (int i = 0; i < max_cycles && eq.size() != 0; i++) @(negedge clk);
    check(eq.size() == 0, "R8", "pending descriptors", eq.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check(o_valid == 1'b0, "R1", "o_valid in reset", o_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(o_valid == 1'b0, "R1", "o_valid after reset", o_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // table walk
    for (int i = 0; i < NE; i++) push(EXP[i], ETAG[i]);
    for (int i = 0; i < NS; i++) send(STIM[i]);
    drain(40);

    // R6: saturation, 10 hits of height 7 sum to 70
    for (int r = 20; r < 30; r++) send('{1'b0, 7'(r), 5'd5, 8'd2, 3'd7});
    push('{1'b0, 5'd5, 7'd20, 7'd29, 8'd2, 6'd63}, 6);
    push('{1'b1, 5'd9, 7'd3, 7'd3, 8'd7, 6'd6}, 7);
    send('{1'b1, 7'd3, 5'd9, 8'd7, 3'd6});
    drain(20);

    // R8 / R3: stall behaviour and latency
    @(negedge clk);
    o_ready = 1'b0;
    send('{1'b0, 7'd40, 5'd1, 8'd0, 3'd1});
    send('{1'b0, 7'd50, 5'd1, 8'd0, 3'd2});     // closes row 40
    @(negedge clk);
    #1;
    check(o_valid == 1'b1, "R3", "valid one cycle after close", o_valid, 1);
    check(o_row_first == 7'd40, "R3", "closed cluster row", o_row_first, 40);
    push('{1'b0, 5'd1, 7'd40, 7'd40, 8'd0, 6'd1}, 8);
    // extension accepted while stalled
    @(negedge clk);
    drive('{1'b0, 7'd51, 5'd1, 8'd0, 3'd3});
    #1;
    check(in_ready == 1'b1, "R8", "extend while stalled", in_ready, 1);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    // closing hit refused while stalled
    @(negedge clk);
    drive('{1'b0, 7'd60, 5'd1, 8'd0, 3'd4});
    for (int k = 0; k < 3; k++) begin
      #1;
      check(in_ready == 1'b0, "R8", "refuse while stalled", in_ready, 0);
      check(o_valid == 1'b1 && o_row_first == 7'd40, "R8", "held row", o_row_first, 40);
      @(negedge clk);
    end
    o_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R8", "accept while draining", in_ready, 1);
    push('{1'b0, 5'd1, 7'd50, 7'd51, 8'd0, 6'd5}, 8);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    push('{1'b0, 5'd1, 7'd60, 7'd60, 8'd0, 6'd4}, 7);
    push('{1'b1, 5'd0, 7'd0, 7'd0, 8'd0, 6'd0}, 7);
    send('{1'b1, 7'd0, 5'd0, 8'd0, 3'd0});
    drain(20);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule